// File: doc/BRIEF.md
# Reciprocal Square Root Operand Prefixup

This block takes one IEEE-754 binary32 value that is about to enter an iterative reciprocal-square-root sequence and gets it ready for that loop. Inputs that need no iteration are settled here. NaNs, negative nonzero values, infinities and zeros each map to a fixed operand and seed pair. A positive finite value instead goes to the iterative path. If it is very small, it is first multiplied by two to the 64th, so that the loop runs on a well-ranged number. An adjust code then tells the later correction stage to undo the scaling in the result exponent.

The decision logic is purely combinational. Its results are captured in one output register stage with a synchronous active-high reset. A value presented before a rising clock edge appears on the outputs just after that edge. The iteration and the final exponent correction belong to other blocks.

Top module: `rsq_prefix`

## Requirements
- R1: While reset is high, and in the cycle that follows it, every output is zero.
- R2: Outputs are registered: they show the result for the input sampled at the most recent rising edge, and they do not change between edges.
- R3: A NaN input (exponent field all ones, fraction nonzero, either sign) gives operand 0xFFFFFFFF and seed 0xFFFFFFFF, with adjust 0 and the iteration flag 0. Invalid is 1 exactly when fraction bit 22 (the quiet bit) is 0.
- R4: A negative nonzero non-NaN input (sign bit 31 set; this includes negative infinity and negative subnormals) gives operand and seed 0xFFFFFFFF, invalid 1, adjust 0 and the iteration flag 0.
- R5: Positive infinity (0x7F800000) gives operand and seed 0x7F800000, with invalid, adjust and iteration flag all 0.
- R6: A zero input of either sign passes through unchanged as the operand and gives seed 0x3F800000 (1.0), with invalid, adjust and iteration flag all 0.
- R7: A positive finite nonzero input gives seed 0, iteration flag 1 and invalid 0.
- R8: A positive normal input whose biased exponent field (bits 30:23) is 24 or less has 64 added to that field, keeps its fraction, and gets adjust 0xE0.
- R9: A positive subnormal input is normalized and scaled by 2^64. If its highest set fraction bit is at position p, the operand gets biased exponent p+42 and the bits below that leading one, shifted up to the top of the fraction. Adjust is 0xE0.
- R10: A positive normal input whose biased exponent field is above 24 passes through unchanged, with adjust 0.
- R11: The iteration flag and invalid are never 1 together. A nonzero adjust code only appears together with the iteration flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_val | input | 32 | binary32 operand to prepare |
| fix_op | output | 32 | Prepared (possibly scaled) operand |
| seed | output | 32 | Seed result; final value for special cases, 0 otherwise |
| adj_code | output | 8 | Exponent adjust code (0xE0 when prescaled, else 0) |
| need_iter | output | 1 | High when the iterative computation must run |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Some relations hold on every cycle and are checked by assertions. The iteration flag and invalid never overlap. A nonzero adjust code implies iteration. Invalid always comes with canonical NaN on both outputs. Positive infinity and large normals map through one register. The leading-one detector never sees more than one hit. The exact bit patterns cannot be shown by those invariants and only the bench's scenarios exercise them. These are the scaled operand at the exponent boundary of 24/25, subnormal normalization at both fraction ends, the quiet-bit dependence of invalid, negative zero taking the zero path, and the one-cycle output timing.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // Default binary32 geometry used by every module in the block
  localparam int FMT_EXP_W  = 8;
  localparam int FMT_FRAC_W = 23;

  // Operand class, in the priority order used by the selector
  typedef enum logic [2:0] {
    K_NAN  = 3'd0,
    K_NEG  = 3'd1,
    K_INF  = 3'd2,
    K_ZERO = 3'd3,
    K_NORM = 3'd4,
    K_SUB  = 3'd5
  } kind_e;

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
#(
  parameter int EXP_W  = FMT_EXP_W,
  parameter int FRAC_W = FMT_FRAC_W,
  localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [FP_W-1:0] val_i,
  output kind_e           kind_o,
  output logic            quiet_o
);

  logic              sign;
  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_zero;

  assign sign      = val_i[FP_W-1];
  assign expf      = val_i[FP_W-2 -: EXP_W];
  assign frac      = val_i[FRAC_W-1:0];
  assign exp_ones  = &expf;
  assign exp_zero  = ~|expf;
  assign frac_zero = ~|frac;
  assign quiet_o   = frac[FRAC_W-1];

  // NaN wins over sign; signed zero is a zero, not a negative value
  always_comb begin
    if (exp_ones && !frac_zero)      kind_o = K_NAN;
    else if (exp_zero && frac_zero)  kind_o = K_ZERO;
    else if (sign)                   kind_o = K_NEG;
    else if (exp_ones)               kind_o = K_INF;
    else if (exp_zero)               kind_o = K_SUB;
    else                             kind_o = K_NORM;
  end

endmodule

// File: rtl/rsq_lead_one.sv
module rsq_lead_one #(
  parameter int  W  = 23,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);

  logic [W-1:0] hit;

  // hit[i]: bit i set and no higher bit set
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_hit
      if (gi == W - 1) begin : g_top
        assign hit[gi] = vec_i[gi];
      end else begin : g_low
        assign hit[gi] = vec_i[gi] & ~(|vec_i[W-1:gi+1]);
      end
    end
  endgenerate

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) pos_o = pos_o | PW'(i);
    end
  end

  assign any_o = |vec_i;

  // Priority chain must never flag two positions (R9)
  always_comb begin
    p_single_lead_r9: assert ($onehot0(hit))
      else $error("leading-one detector flagged several bits");
  end

endmodule

// File: rtl/rsq_prescale.sv
module rsq_prescale #(
  parameter int  EXP_W  = 8,
  parameter int  FRAC_W = 23,
  parameter int  SHIFT  = 64,
  parameter int  LIMIT  = 24,
  localparam int FP_W   = 1 + EXP_W + FRAC_W,
  localparam int POS_W  = $clog2(FRAC_W),
  localparam int SUB_BASE = SHIFT + 1 - FRAC_W
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FP_W-1:0]   val_o,
  output logic              scaled_o
);

  localparam logic [EXP_W-1:0]  SHIFT_E = EXP_W'(SHIFT);
  localparam logic [EXP_W-1:0]  LIMIT_E = EXP_W'(LIMIT);
  localparam logic [EXP_W-1:0]  BASE_E  = EXP_W'(SUB_BASE);
  localparam logic [POS_W:0]    FW_E    = (POS_W+1)'(FRAC_W);

  logic [POS_W-1:0]  lead_pos;
  logic              lead_any;
  logic [POS_W:0]    shamt;
  logic [EXP_W-1:0]  new_exp;
  logic [FRAC_W-1:0] new_frac;
  logic              is_sub;

  rsq_lead_one #(.W(FRAC_W)) u_lead (
    .vec_i (frac_i),
    .pos_o (lead_pos),
    .any_o (lead_any)
  );

  assign is_sub = ~|exp_i;
  assign shamt  = FW_E - {1'b0, lead_pos};

  always_comb begin
    if (is_sub) begin
      // Leading one lands just above the fraction field and drops out
      new_frac = frac_i << shamt;
      new_exp  = BASE_E + EXP_W'(lead_pos);
      scaled_o = lead_any;
    end else begin
      new_frac = frac_i;
      new_exp  = exp_i + SHIFT_E;
      scaled_o = (exp_i <= LIMIT_E);
    end
    val_o = scaled_o ? {1'b0, new_exp, new_frac} : {1'b0, exp_i, frac_i};
  end

  // A scaled subnormal always becomes a normal number (R9)
  always_comb begin
    if (is_sub && lead_any) begin
      p_sub_normalized_r9: assert (new_exp != '0)
        else $error("scaled subnormal kept a zero exponent");
    end
  end

endmodule

// File: rtl/rsq_select.sv
module rsq_select
  import rsq_pkg::*;
#(
  parameter int  EXP_W  = FMT_EXP_W,
  parameter int  FRAC_W = FMT_FRAC_W,
  parameter int  ADJ_W  = 8,
  parameter logic [ADJ_W-1:0] ADJ_SCALED = 8'hE0,
  localparam int FP_W   = 1 + EXP_W + FRAC_W
) (
  input  kind_e            kind_i,
  input  logic             quiet_i,
  input  logic [FP_W-1:0]  val_i,
  input  logic [FP_W-1:0]  scaled_val_i,
  input  logic             scaled_i,
  output logic [FP_W-1:0]  op_o,
  output logic [FP_W-1:0]  seed_o,
  output logic [ADJ_W-1:0] adj_o,
  output logic             iter_o,
  output logic             inv_o
);

  localparam logic [FP_W-1:0] CANON_NAN = '1;
  localparam logic [FP_W-1:0] POS_INF   = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [FP_W-1:0] ONE_VAL   = {2'b00, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};

  always_comb begin
    op_o   = val_i;
    seed_o = '0;
    adj_o  = '0;
    iter_o = 1'b0;
    inv_o  = 1'b0;
    unique case (kind_i)
      K_NAN: begin
        op_o   = CANON_NAN;
        seed_o = CANON_NAN;
        inv_o  = ~quiet_i;
      end
      K_NEG: begin
        op_o   = CANON_NAN;
        seed_o = CANON_NAN;
        inv_o  = 1'b1;
      end
      K_INF: begin
        op_o   = POS_INF;
        seed_o = POS_INF;
      end
      K_ZERO: begin
        seed_o = ONE_VAL;
      end
      K_NORM, K_SUB: begin
        op_o   = scaled_val_i;
        adj_o  = scaled_i ? ADJ_SCALED : '0;
        iter_o = 1'b1;
      end
      default: begin
        op_o = val_i;
      end
    endcase
  end

endmodule

// File: rtl/rsq_prefix.sv
module rsq_prefix
  import rsq_pkg::*;
#(
  parameter int  EXP_W  = FMT_EXP_W,
  parameter int  FRAC_W = FMT_FRAC_W,
  parameter int  ADJ_W  = 8,
  parameter int  SCALE_SHIFT = 64,
  parameter int  SCALE_LIMIT = 24,
  parameter logic [ADJ_W-1:0] ADJ_SCALED = 8'hE0,
  localparam int FP_W   = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FP_W-1:0]  in_val,
  output logic [FP_W-1:0]  fix_op,
  output logic [FP_W-1:0]  seed,
  output logic [ADJ_W-1:0] adj_code,
  output logic             need_iter,
  output logic             invalid
);

  localparam logic [FP_W-1:0]  POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [EXP_W-1:0] LIM_E   = EXP_W'(SCALE_LIMIT);

  kind_e             kind;
  logic              quiet;
  logic [FP_W-1:0]   scaled_val;
  logic              scaled;
  logic [FP_W-1:0]   op_d;
  logic [FP_W-1:0]   seed_d;
  logic [ADJ_W-1:0]  adj_d;
  logic              iter_d;
  logic              inv_d;

  rsq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
    .val_i   (in_val),
    .kind_o  (kind),
    .quiet_o (quiet)
  );

  rsq_prescale #(
    .EXP_W (EXP_W), .FRAC_W (FRAC_W),
    .SHIFT (SCALE_SHIFT), .LIMIT (SCALE_LIMIT)
  ) u_scale (
    .exp_i    (in_val[FP_W-2 -: EXP_W]),
    .frac_i   (in_val[FRAC_W-1:0]),
    .val_o    (scaled_val),
    .scaled_o (scaled)
  );

  rsq_select #(
    .EXP_W (EXP_W), .FRAC_W (FRAC_W),
    .ADJ_W (ADJ_W), .ADJ_SCALED (ADJ_SCALED)
  ) u_sel (
    .kind_i       (kind),
    .quiet_i      (quiet),
    .val_i        (in_val),
    .scaled_val_i (scaled_val),
    .scaled_i     (scaled),
    .op_o         (op_d),
    .seed_o       (seed_d),
    .adj_o        (adj_d),
    .iter_o       (iter_d),
    .inv_o        (inv_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_op    <= '0;
      seed      <= '0;
      adj_code  <= '0;
      need_iter <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      fix_op    <= op_d;
      seed      <= seed_d;
      adj_code  <= adj_d;
      need_iter <= iter_d;
      invalid   <= inv_d;
    end
  end

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fix_op == '0 && seed == '0 && adj_code == '0 && !need_iter && !invalid));

  p_iter_inv_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(need_iter && invalid));

  p_adj_needs_iter_r11: assert property (@(posedge clk) disable iff (rst)
    (adj_code != '0) |-> need_iter);

  p_iter_seed_zero_r7: assert property (@(posedge clk) disable iff (rst)
    need_iter |-> (seed == '0));

  p_invalid_canon_r4: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (fix_op == '1 && seed == '1));

  p_pos_inf_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_val) == POS_INF) |-> (fix_op == POS_INF && seed == POS_INF));

  p_large_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_val[FP_W-1]) && !(&$past(in_val[FP_W-2 -: EXP_W]))
      && $past(in_val[FP_W-2 -: EXP_W]) > LIM_E)
    |-> (fix_op == $past(in_val) && adj_code == '0 && need_iter));

endmodule

// File: tb/rsq_prefix_tb.sv
`timescale 1ns/1ps
module rsq_prefix_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_val = 32'h0;
  logic [31:0] fix_op, seed;
  logic [7:0]  adj_code;
  logic        need_iter, invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rsq_prefix u_dut (
    .clk (clk), .rst (rst), .in_val (in_val),
    .fix_op (fix_op), .seed (seed), .adj_code (adj_code),
    .need_iter (need_iter), .invalid (invalid)
  );

  // Reference model, computed from the requirements with integers
  function automatic logic [73:0] model(input logic [31:0] x);
    int e, f, p, ne, nf;
    e = int'(x[30:23]);
    f = int'(x[22:0]);
    if (e == 255 && f != 0) return {32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, ~x[22]};
    if (e == 0 && f == 0)   return {x, 32'h3F800000, 8'h00, 1'b0, 1'b0};
    if (x[31])              return {32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0, 1'b1};
    if (e == 255)           return {32'h7F800000, 32'h7F800000, 8'h00, 1'b0, 1'b0};
    if (e == 0) begin
      p = 0;
      for (int i = 0; i < 23; i++) if (((f >> i) & 1) == 1) p = i;
      ne = p + 42;
      nf = (f << (23 - p)) & 32'h007FFFFF;
      return {1'b0, ne[7:0], nf[22:0], 32'h0, 8'hE0, 1'b1, 1'b0};
    end
    if (e <= 24) begin
      ne = e + 64;
      return {1'b0, ne[7:0], x[22:0], 32'h0, 8'hE0, 1'b1, 1'b0};
    end
    return {x, 32'h0, 8'h00, 1'b1, 1'b0};
  endfunction

  function automatic string tag_of(input logic [31:0] x);
    if (x[30:23] == 8'hFF && x[22:0] != 0) return "R3 R11";
    if (x[30:0] == 0)                      return "R6 R11";
    if (x[31])                             return "R4 R11";
    if (x[30:23] == 8'hFF)                 return "R5 R11";
    if (x[30:23] == 0)                     return "R9 R7";
    if (x[30:23] <= 8'd24)                 return "R8 R7";
    return "R10 R7";
  endfunction

  task automatic compare(input logic [73:0] exp_v, input string tag);
    logic [73:0] act;
    act = {fix_op, seed, adj_code, need_iter, invalid};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual op=%h seed=%h adj=%h it=%b inv=%b expected op=%h seed=%h adj=%h it=%b inv=%b",
               tag, act[73:42], act[41:10], act[9:2], act[1], act[0],
               exp_v[73:42], exp_v[41:10], exp_v[9:2], exp_v[1], exp_v[0]);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic apply(input logic [31:0] v);
    @(negedge clk);
    in_val = v;
    @(negedge clk);
    compare(model(v), tag_of(v));
  endtask

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs held at zero during reset with a busy input
    in_val = 32'h0C000000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(74'h0, "R1");
    rst = 1'b0;

    // NaNs: quiet, signaling, negative signaling (R3)
    apply(32'h7FC00000);
    apply(32'h7F800001);
    apply(32'hFFFFFFFF);
    apply(32'hFF800001);
    // Negative nonzero values (R4)
    apply(32'hBF800000);
    apply(32'hFF800000);
    apply(32'h80000001);
    // Positive infinity (R5)
    apply(32'h7F800000);
    // Both zeros (R6)
    apply(32'h00000000);
    apply(32'h80000000);
    // Normal boundary around exponent 24 (R8, R10)
    apply(32'h0C000000);
    apply(32'h0C7FFFFF);
    apply(32'h0C800000);
    apply(32'h00800000);
    apply(32'h3F800000);
    apply(32'h7F7FFFFF);
    // Subnormals at both ends of the fraction (R9)
    apply(32'h00000001);
    apply(32'h00400000);
    apply(32'h007FFFFF);
    apply(32'h00012345);

    // R2: output holds between edges, then follows the new input
    apply(32'h3F800000);
    @(negedge clk);
    in_val = 32'h00000001;
    #1;
    compare(model(32'h3F800000), "R2");
    @(negedge clk);
    compare(model(32'h00000001), "R2");

    // R1: reset in mid-run clears the outputs
    @(negedge clk);
    rst = 1'b1;
    in_val = 32'h7FC00000;
    @(negedge clk);
    compare(74'h0, "R1");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare(model(32'h7FC00000), "R1 R3");

    // Mixed sweep, biased toward small and extreme exponents
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] v;
      rng = next_rng(rng);
      v = rng;
      case (rng[1:0])
        2'd0: v[30:23] = 8'h00;
        2'd1: v[30:23] = 8'hFF;
        2'd2: v[30:23] = 8'(rng[7:3] % 27);
        default: ;
      endcase
      apply(v);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule